// File: doc/BRIEF.md
# Vector Length Configuration Unit

This unit carries out vector-configuration operations. Each operation brings a requested element-type word and, depending on its mode, a requested application vector length (AVL). The unit decodes the element width and the register-grouping factor out of the type word, decides whether that pair is supported, and works out the largest vector length the pair allows. The maximum is the vector register size in bits, multiplied by the grouping factor and divided by the element width. The unit then updates the vector-length register (vl) and the type register (vtype). The type register includes an illegal-configuration flag in its top bit.

The type word comes from one of two sources. An immediate word has only a narrow field of meaningful bits. A full register word is the source used when saved state is restored after a context switch, and it may already carry the illegal flag. The length comes from one of three modes: from the AVL operand, set to the maximum, or kept as it is when both the source and the destination are the zero register. The illegal flag depends only on the width and grouping that are requested. A change of length never raises it, and whenever the flag is set, vl reads zero. The new vl is returned for the destination register one cycle after the operation is presented.

Top module: `vcfg_unit`

## Requirements
- R1: After reset, vtype_o reads 0x8000_0000 (only the illegal flag in bit 31 set), vl_o reads 0 and res_valid_o is low.
- R2: The vtype word holds the width code in bits [5:3] (0..3 mean 8, 16, 32 and 64 bits) and the grouping code in bits [2:0] (0..3 mean 1, 2, 4 and 8; 7, 6 and 5 mean 1/2, 1/4 and 1/8; 4 is reserved). A supported setting is stored with these two fields only, and the maximum length is 128 × grouping / width.
- R3: In AVL mode (avl_mode_i = 0, and code 3 behaves the same), vl becomes min(AVL, maximum length). The comparison uses the full 32-bit AVL, so an AVL at or above 256 still gives the maximum and does not wrap.
- R4: A setting is unsupported when its maximum length is below 1, when the grouping code is 4, when the width code is 4 or above (wider than the 64-bit element limit), or when any of bits [10:6] is set. An unsupported setting makes vtype_o read exactly 0x8000_0000 and vl_o read 0.
- R5: With a register-supplied type (type_sel_i = 1), any set bit in [31:6] makes the setting unsupported. This includes bit 31, the illegal flag of a restored word. The result is vtype 0x8000_0000 and vl 0.
- R6: With an immediate type (type_sel_i = 0), bits 31..11 of type_i are ignored, bit 31 included.
- R7: In maximum mode (avl_mode_i = 1), a supported setting sets vl to the maximum length, and the AVL value has no effect.
- R8: In keep mode (avl_mode_i = 2), a supported setting updates vtype and leaves vl unchanged without raising the illegal flag, even when the old vl exceeds the new maximum. An unsupported setting still gives vtype 0x8000_0000 and vl 0.
- R9: res_valid_o is high exactly in the cycle after a cycle with valid_i high, and res_o then equals the new vl. When valid_i is low, vl and vtype hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| valid_i | input | 1 | An operation is presented in this cycle |
| type_sel_i | input | 1 | 0: immediate type word, 1: register-supplied type word |
| avl_mode_i | input | 2 | 0/3: use AVL, 1: maximum length, 2: keep current length |
| avl_i | input | 32 | Requested application vector length |
| type_i | input | 32 | Requested element-type word |
| vl_o | output | 8 | Current vector length |
| vtype_o | output | 32 | Current type register, illegal flag in bit 31 |
| res_valid_o | output | 1 | Destination-register result is valid |
| res_o | output | 32 | Destination-register result (new vl) |

## Verification
The length computation is tried with AVLs below the maximum, above it, equal to zero and at 256. Only the 256 case shows whether the comparison uses the full AVL width or a truncated one. Supported settings cover integer and fractional grouping at several widths, including the smallest legal case of one element. Unsupported ones are reached in turn through a too-small ratio, the reserved grouping code, an oversized width, a reserved bit and a restored illegal flag, so that each cause of the flag is seen on its own. Keep mode is run from a nonzero length onto a setting with a smaller maximum, and again from the illegal state, which separates keeping vl from clamping or recomputing it.

// File: rtl/vcfg_pkg.sv
package vcfg_pkg;
    typedef enum logic [1:0] {
        AVL_FROM_REG = 2'd0,
        AVL_SET_MAX  = 2'd1,
        AVL_KEEP     = 2'd2,
        AVL_ALT_REG  = 2'd3
    } avl_mode_e;

    localparam int WCODE_LSB = 3;
    localparam int GCODE_LSB = 0;
    localparam int CODE_W    = 3;
    localparam int FIELD_TOP = 6;
endpackage

// File: rtl/vcfg_decode.sv
module vcfg_decode
    import vcfg_pkg::*;
#(
    parameter int XLEN  = 32,
    parameter int VLEN  = 128,
    parameter int ELEN  = 64,
    parameter int IMM_W = 11,
    localparam int LOG_VLEN = $clog2(VLEN),
    localparam int VL_W     = LOG_VLEN + 1
) (
    input  logic [XLEN-1:0]   type_i,
    input  logic              type_is_reg_i,
    output logic              legal_o,
    output logic [CODE_W-1:0] wcode_o,
    output logic [CODE_W-1:0] gcode_o,
    output logic [VL_W-1:0]   vlmax_o
);
    localparam int LOG_ELEN = $clog2(ELEN);
    localparam logic [VL_W-1:0] ONE = VL_W'(1);

    logic        grp_ok;
    logic        rsv_clear;
    int          grp_shift;
    logic [VL_W-1:0] vlmax_by_w [8];
    logic            fits_by_w  [8];

    assign wcode_o = type_i[WCODE_LSB +: CODE_W];
    assign gcode_o = type_i[GCODE_LSB +: CODE_W];

    // reserved bits: immediate form looks only below IMM_W, register form at all
    always_comb begin
        if (type_is_reg_i) rsv_clear = (type_i[XLEN-1:FIELD_TOP] == '0);
        else               rsv_clear = (type_i[IMM_W-1:FIELD_TOP] == '0);
    end

    always_comb begin
        grp_ok    = 1'b1;
        grp_shift = 0;
        case (gcode_o)
            3'd0: grp_shift = 0;
            3'd1: grp_shift = 1;
            3'd2: grp_shift = 2;
            3'd3: grp_shift = 3;
            3'd5: grp_shift = -3;
            3'd6: grp_shift = -2;
            3'd7: grp_shift = -1;
            default: grp_ok = 1'b0;
        endcase
    end

    for (genvar gw = 0; gw < 8; gw++) begin : g_width
        localparam int  SEW_LOG = 3 + gw;
        localparam bit  W_OK    = (gw < 4) && (SEW_LOG <= LOG_ELEN);
        int l2;
        always_comb begin
            l2 = LOG_VLEN - SEW_LOG + grp_shift;
            fits_by_w[gw]  = W_OK && grp_ok && (l2 >= 0);
            vlmax_by_w[gw] = fits_by_w[gw] ? (ONE << l2) : '0;
        end
    end

    assign legal_o = rsv_clear && fits_by_w[wcode_o];
    assign vlmax_o = legal_o ? vlmax_by_w[wcode_o] : '0;
endmodule

// File: rtl/vcfg_vl_sel.sv
module vcfg_vl_sel
    import vcfg_pkg::*;
#(
    parameter int XLEN = 32,
    parameter int VL_W = 8
) (
    input  logic [XLEN-1:0] avl_i,
    input  logic [1:0]      mode_i,
    input  logic            legal_i,
    input  logic [VL_W-1:0] vlmax_i,
    input  logic [VL_W-1:0] cur_vl_i,
    output logic [VL_W-1:0] vl_o
);
    logic avl_big;

    // full-width compare so that AVL bits above VL_W are never dropped
    assign avl_big = (avl_i >= XLEN'(vlmax_i));

    always_comb begin
        if (!legal_i) begin
            vl_o = '0;
        end else begin
            case (avl_mode_e'(mode_i))
                AVL_SET_MAX: vl_o = vlmax_i;
                AVL_KEEP:    vl_o = cur_vl_i;
                default:     vl_o = avl_big ? vlmax_i : avl_i[VL_W-1:0];
            endcase
        end
    end
endmodule

// File: rtl/vcfg_unit.sv
module vcfg_unit
    import vcfg_pkg::*;
#(
    parameter int XLEN  = 32,
    parameter int VLEN  = 128,
    parameter int ELEN  = 64,
    parameter int IMM_W = 11,
    localparam int VL_W = $clog2(VLEN) + 1
) (
    input  logic            clk_i,
    input  logic            rst_ni,
    input  logic            valid_i,
    input  logic            type_sel_i,
    input  logic [1:0]      avl_mode_i,
    input  logic [XLEN-1:0] avl_i,
    input  logic [XLEN-1:0] type_i,
    output logic [VL_W-1:0] vl_o,
    output logic [XLEN-1:0] vtype_o,
    output logic            res_valid_o,
    output logic [XLEN-1:0] res_o
);
    typedef struct packed {
        logic [VL_W-1:0]   vl;
        logic              ill;
        logic [CODE_W-1:0] wcode;
        logic [CODE_W-1:0] gcode;
        logic              res_valid;
        logic [XLEN-1:0]   res;
    } cfg_state_t;

    cfg_state_t st_d, st_q;

    logic              dec_legal;
    logic [CODE_W-1:0] dec_wcode;
    logic [CODE_W-1:0] dec_gcode;
    logic [VL_W-1:0]   dec_vlmax;
    logic [VL_W-1:0]   new_vl;

    vcfg_decode #(
        .XLEN (XLEN),
        .VLEN (VLEN),
        .ELEN (ELEN),
        .IMM_W(IMM_W)
    ) u_decode (
        .type_i       (type_i),
        .type_is_reg_i(type_sel_i),
        .legal_o      (dec_legal),
        .wcode_o      (dec_wcode),
        .gcode_o      (dec_gcode),
        .vlmax_o      (dec_vlmax)
    );

    vcfg_vl_sel #(
        .XLEN(XLEN),
        .VL_W(VL_W)
    ) u_vl_sel (
        .avl_i   (avl_i),
        .mode_i  (avl_mode_i),
        .legal_i (dec_legal),
        .vlmax_i (dec_vlmax),
        .cur_vl_i(st_q.vl),
        .vl_o    (new_vl)
    );

    always_comb begin
        st_d           = st_q;
        st_d.res_valid = 1'b0;
        if (valid_i) begin
            st_d.vl        = new_vl;
            st_d.ill       = !dec_legal;
            st_d.wcode     = dec_legal ? dec_wcode : '0;
            st_d.gcode     = dec_legal ? dec_gcode : '0;
            st_d.res_valid = 1'b1;
            st_d.res       = XLEN'(new_vl);
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q       <= '0;
            st_q.ill   <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign vl_o        = st_q.vl;
    assign vtype_o     = {st_q.ill, {(XLEN-1-FIELD_TOP){1'b0}}, st_q.wcode, st_q.gcode};
    assign res_valid_o = st_q.res_valid;
    assign res_o       = st_q.res;
endmodule

// File: rtl/vcfg_unit_chk.sv
module vcfg_unit_chk #(
    parameter int XLEN = 32,
    parameter int VL_W = 8,
    parameter int VLEN = 128
) (
    input logic            clk_i,
    input logic            rst_ni,
    input logic            valid_i,
    input logic [1:0]      avl_mode_i,
    input logic [VL_W-1:0] vl_o,
    input logic [XLEN-1:0] vtype_o,
    input logic            res_valid_o,
    input logic [XLEN-1:0] res_o
);
    AST_ILL_ZERO_VL: assert property (@(posedge clk_i) disable iff (!rst_ni)
        vtype_o[XLEN-1] |-> (vl_o == '0)); // R4
    AST_ILL_CLEAN_TYPE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        vtype_o[XLEN-1] |-> (vtype_o[XLEN-2:0] == '0)); // R4
    AST_VL_BOUNDED: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (int'(vl_o) <= VLEN)); // R3
    AST_RES_FOLLOWS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        valid_i |=> res_valid_o); // R9
    AST_IDLE_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !valid_i |=> (!res_valid_o && $stable(vl_o) && $stable(vtype_o))); // R9
    AST_RES_IS_VL: assert property (@(posedge clk_i) disable iff (!rst_ni)
        res_valid_o |-> (res_o == XLEN'(vl_o))); // R9
    AST_KEEP_LENGTH: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (valid_i && avl_mode_i == 2'd2) |=> (vtype_o[XLEN-1] || vl_o == $past(vl_o))); // R8
endmodule

bind vcfg_unit vcfg_unit_chk #(
    .XLEN(XLEN),
    .VL_W(VL_W),
    .VLEN(VLEN)
) u_chk (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .valid_i    (valid_i),
    .avl_mode_i (avl_mode_i),
    .vl_o       (vl_o),
    .vtype_o    (vtype_o),
    .res_valid_o(res_valid_o),
    .res_o      (res_o)
);

// File: tb/vcfg_unit_bench.sv
module vcfg_unit_bench;
    localparam logic [31:0] ILL = 32'h8000_0000;

    logic        clk_i = 1'b0;
    logic        rst_ni = 1'b0;
    logic        valid_i = 1'b0;
    logic        type_sel_i = 1'b0;
    logic [1:0]  avl_mode_i = 2'd0;
    logic [31:0] avl_i = '0;
    logic [31:0] type_i = '0;
    logic [7:0]  vl_o;
    logic [31:0] vtype_o;
    logic        res_valid_o;
    logic [31:0] res_o;

    int total = 0;
    int bad = 0;
    int cycles = 0;

    always #4 clk_i = ~clk_i;

    vcfg_unit u_vcfg_unit (
        .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i), .type_sel_i(type_sel_i),
        .avl_mode_i(avl_mode_i), .avl_i(avl_i), .type_i(type_i), .vl_o(vl_o),
        .vtype_o(vtype_o), .res_valid_o(res_valid_o), .res_o(res_o)
    );

    function automatic logic [31:0] vt(input int w, input int g);
        return 32'((w << 3) | g);
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // present one operation, then sample at the following falling edge
    task automatic op(input logic sel, input logic [1:0] mode, input logic [31:0] avl,
                      input logic [31:0] tw);
        @(negedge clk_i);
        valid_i = 1'b1; type_sel_i = sel; avl_mode_i = mode; avl_i = avl; type_i = tw;
        @(negedge clk_i);
        valid_i = 1'b0;
    endtask

    task automatic expect_state(input string req, input logic [31:0] exp_vl,
                                input logic [31:0] exp_vt);
        chk(req, {24'd0, vl_o}, exp_vl);
        chk(req, vtype_o, exp_vt);
        chk(req, {31'd0, res_valid_o}, 32'd1);
        chk(req, res_o, exp_vl);
    endtask

    task automatic t_reset;
        chk("R1 vtype", vtype_o, ILL);
        chk("R1 vl", {24'd0, vl_o}, 32'd0);
        chk("R1 res_valid", {31'd0, res_valid_o}, 32'd0);
    endtask

    task automatic t_legal;
        op(1'b0, 2'd0, 32'd100, vt(0, 0));   expect_state("R2 e8 m1", 16, 32'h00);
        op(1'b0, 2'd0, 32'd1000, vt(2, 3));  expect_state("R2 e32 m8", 32, 32'h13);
        op(1'b0, 2'd0, 32'd9, vt(3, 7));     expect_state("R2 e64 mf2", 1, 32'h1F);
        op(1'b1, 2'd0, 32'd50, vt(1, 6));    expect_state("R2 e16 mf4", 2, 32'h0E);
    endtask

    task automatic t_min;
        op(1'b0, 2'd0, 32'd5, vt(0, 3));     expect_state("R3 below max", 5, 32'h03);
        op(1'b0, 2'd0, 32'h100, vt(0, 0));   expect_state("R3 avl 256 no wrap", 16, 32'h00);
        op(1'b0, 2'd3, 32'd0, vt(0, 0));     expect_state("R3 avl zero code3", 0, 32'h00);
        op(1'b0, 2'd0, 32'd128, vt(0, 3));   expect_state("R3 equal max", 128, 32'h03);
    endtask

    task automatic t_illegal;
        op(1'b0, 2'd0, 32'd100, vt(0, 0));
        op(1'b0, 2'd0, 32'd100, vt(3, 6));   expect_state("R4 ratio too small", 0, ILL);
        op(1'b0, 2'd0, 32'd100, vt(0, 0));
        op(1'b0, 2'd0, 32'd100, vt(0, 4));   expect_state("R4 reserved group", 0, ILL);
        op(1'b0, 2'd0, 32'd100, vt(0, 0));
        op(1'b0, 2'd0, 32'd100, vt(4, 0));   expect_state("R4 width over limit", 0, ILL);
        op(1'b0, 2'd0, 32'd100, vt(0, 0));
        op(1'b0, 2'd0, 32'd100, vt(0, 0) | 32'h40); expect_state("R4 reserved bit6", 0, ILL);
    endtask

    task automatic t_restore;
        op(1'b1, 2'd0, 32'd7, vt(1, 1));     expect_state("R5 reg legal", 7, 32'h09);
        op(1'b1, 2'd0, 32'd7, ILL | vt(1, 1)); expect_state("R5 restored illegal", 0, ILL);
        op(1'b1, 2'd0, 32'd7, vt(1, 1));
        op(1'b1, 2'd0, 32'd7, 32'h800 | vt(0, 0)); expect_state("R5 reg bit11", 0, ILL);
    endtask

    task automatic t_imm_ignore;
        op(1'b0, 2'd0, 32'd100, ILL | 32'h800 | vt(1, 0));
        expect_state("R6 upper bits ignored", 8, 32'h08);
    endtask

    task automatic t_max;
        op(1'b0, 2'd1, 32'd3, vt(1, 1));     expect_state("R7 max mode", 16, 32'h09);
        op(1'b0, 2'd1, 32'd0, vt(0, 5));     expect_state("R7 max frac", 2, 32'h05);
    endtask

    task automatic t_keep;
        op(1'b0, 2'd0, 32'd10, vt(0, 0));    expect_state("R8 setup", 10, 32'h00);
        op(1'b0, 2'd2, 32'd99, vt(2, 0));    expect_state("R8 keep over new max", 10, 32'h10);
        op(1'b0, 2'd2, 32'd99, vt(5, 0));    expect_state("R8 keep unsupported", 0, ILL);
        op(1'b0, 2'd2, 32'd99, vt(0, 0));    expect_state("R8 keep from illegal", 0, 32'h00);
    endtask

    task automatic t_idle;
        op(1'b0, 2'd0, 32'd6, vt(0, 0));
        @(negedge clk_i);
        @(negedge clk_i);
        type_i = ILL; avl_i = 32'd1;
        @(negedge clk_i);
        chk("R9 idle res_valid", {31'd0, res_valid_o}, 32'd0);
        chk("R9 idle vl held", {24'd0, vl_o}, 32'd6);
        chk("R9 idle vtype held", vtype_o, 32'h00);
    endtask

    initial begin
        while (1) begin
            @(posedge clk_i);
            cycles++;
            if (cycles > 20000) begin
                bad++;
                total++;
                $display("FAIL R9 watchdog: actual=%0d expected<=20000 cycles", cycles);
                $display("test done: total=%0d bad=%0d", total, bad);
                $finish;
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk_i);
        t_reset();
        rst_ni = 1'b1;
        t_legal();
        t_min();
        t_illegal();
        t_restore();
        t_imm_ignore();
        t_max();
        t_keep();
        t_idle();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule